// File: doc/BRIEF.md
# Token-Driven Vector Dot-Product Cluster

This block computes the dot product of two signed 16-bit vectors. Each operand vector normally lives in its own small local memory. An address generator walks that memory from a base address by a fixed stride for a given number of elements. The two streams meet in a multiply-accumulate unit. When the last element has been taken, the saturated sum leaves the cluster as one token on the output port.

Every hop between units is a registered link with two toggle lines: a request line owned by the sender and an acknowledge line owned by the receiver. A token is pending while the two lines differ. A unit acts only when its input tokens are pending and its output link is free, and it is idle otherwise.

A host sets the cluster up through a write-only configuration bus: addresses, strides, length, mode bits and memory contents. It then starts the kernel and waits for the done flag, which hands control back. Either operand can instead be taken from an external input port. The output port can acknowledge its own tokens when no receiver is attached. Separate resets clear the link state and the processing state.

Top module: `dotp_cluster`

## Requirements
- R1: A configuration write takes effect on a clock edge where `cfg_stb` is 1, with an 8-bit address and a 16-bit data word. The addresses are as follows. 0x05 is the length. 0x01 and 0x02 are the stream A base and stride. 0x03 and 0x04 are the stream B base and stride. 0x40+k writes word k of memory A and 0x80+k writes word k of memory B, for k below the depth of 16. 0x00 is control: bit 0 starts the kernel, bit 1 selects auto-acknowledge, bit 2 takes operand A from input port A, and bit 3 takes operand B from input port B.
- R2: For element i, from 0 to length-1, a stream reads the memory word whose index is the low 4 bits of base + i*stride, computed modulo 2^16. No address is issued after the last element.
- R3: The result is the sum of the signed products of the element pairs, accumulated in 40 bits. The accumulator starts from zero on the first element of every run, so no earlier run leaks into the result.
- R4: The 40-bit sum is saturated to the signed 16-bit range only when it is sent, so intermediate sums outside that range do not distort a final sum that fits.
- R5: On every link, a new token is a toggle of the request line. The sender toggles it again only after the acknowledge line has toggled to match it.
- R6: With no pending input token, a unit does not fire. In particular, the result is not sent until the last operand token has arrived, however long the gaps between tokens are.
- R7: With an external source selected, each operand is taken from that input port. Its acknowledge output toggles once for each token consumed.
- R8: With auto-acknowledge on, the result token is acknowledged without any `out_ack` activity. With it off, the done flag waits for a toggle of `out_ack`.
- R9: A run emits exactly one output token. The done flag rises after that token is acknowledged and stays set until the next accepted start, which clears it.
- R10: A start with length 0 sets done without emitting a token.
- R11: A control write that requests a start while a run is in progress is ignored. The running kernel finishes with the length it was started with.
- R12: `rst_net_n` low clears all link toggles (`out_req`, `in_a_ack`, `in_b_ack` read 0) and leaves done unchanged. `rst_unit_n` low clears done and the configuration registers. Memory contents survive both resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_net_n | input | 1 | Active-low reset of the link toggles |
| rst_unit_n | input | 1 | Active-low reset of the processing units and configuration |
| cfg_stb | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register or memory address |
| cfg_data | input | 16 | Configuration write data |
| in_a_req | input | 1 | Input port A request toggle |
| in_a_data | input | 16 | Input port A operand |
| in_a_ack | output | 1 | Input port A acknowledge toggle |
| in_b_req | input | 1 | Input port B request toggle |
| in_b_data | input | 16 | Input port B operand |
| in_b_ack | output | 1 | Input port B acknowledge toggle |
| out_req | output | 1 | Output port request toggle |
| out_data | output | 16 | Saturated dot-product result |
| out_ack | input | 1 | Output port acknowledge toggle from the receiver |
| done | output | 1 | Kernel complete, control returned to the host |

## Verification
The hardest case to reach from the ports is a half-fed multiplier. One operand stream has a token waiting while the other has none, and nothing may move. Memory streams always deliver on their own, so the bench takes operand A from its input port. It releases those tokens one at a time with long idle gaps while memory B is ready. Between tokens it checks that no output token and no done flag appear. The sweep also uses a stride of 0xFFFF and strides wider than the memory, so the address wrap and the index truncation are exercised.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // configuration register map
  localparam logic [7:0] REG_CTRL  = 8'h00;
  localparam logic [7:0] REG_BASE0 = 8'h01;  // stream s base at REG_BASE0 + 2*s
  localparam logic [7:0] REG_STEP0 = 8'h02;  // stream s stride at REG_STEP0 + 2*s
  localparam logic [7:0] REG_LEN   = 8'h05;
  // control word bits
  localparam int CTRL_GO   = 0;
  localparam int CTRL_AUTO = 1;
  localparam int CTRL_EXT0 = 2;              // stream s external source at CTRL_EXT0 + s
  localparam int NSTREAM   = 2;
endpackage

// File: rtl/dp_rst_sync.sv
module dp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n = sh_q[1];
endmodule

// File: rtl/dp_agen.sv
module dp_agen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          urst_n,
  input  logic          lrst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] len,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o
);
  logic          active_q, active_d;
  logic [AW-1:0] cur_q, cur_d, idx_q, idx_d, len_q, len_d, step_q, step_d;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic          send;

  assign send = active_q && (req_q == ack_i);

  always_comb begin
    active_d = active_q;
    cur_d    = cur_q;
    idx_d    = idx_q;
    len_d    = len_q;
    step_d   = step_q;
    if (start) begin
      active_d = enable && (len != '0);
      cur_d    = base;
      idx_d    = '0;
      len_d    = len;
      step_d   = stride;
    end else if (send) begin
      cur_d = cur_q + step_q;
      idx_d = idx_q + 1'b1;
      if (idx_q == len_q - 1'b1) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge urst_n) begin
    if (!urst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
      idx_q    <= '0;
      len_q    <= '0;
      step_q   <= '0;
    end else begin
      active_q <= active_d;
      cur_q    <= cur_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
      step_q   <= step_d;
    end
  end

  always_ff @(posedge clk) begin
    if (send) addr_q <= cur_q;
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n)   req_q <= 1'b0;
    else if (send) req_q <= ~req_q;
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;

  // R5
  agen_handshake_chk: assert property (@(posedge clk) disable iff (!lrst_n)
    (req_q != $past(req_q)) |-> ($past(req_q) == $past(ack_i)));
endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     lrst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     a_req,
  input  logic [AW-1:0]            a_addr,
  output logic                     a_ack_o,
  input  logic                     d_ack_i,
  output logic                     d_req_o,
  output logic [DW-1:0]            d_data_o
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] data_q;
  logic          a_ack_q, d_req_q;
  logic          pend, fire;

  assign pend = a_req ^ a_ack_q;
  assign fire = pend && (d_req_q == d_ack_i);

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (fire) data_q <= mem_q[a_addr[IW-1:0]];
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) begin
      a_ack_q <= 1'b0;
      d_req_q <= 1'b0;
    end else if (fire) begin
      a_ack_q <= ~a_ack_q;
      d_req_q <= ~d_req_q;
    end
  end

  assign a_ack_o  = a_ack_q;
  assign d_req_o  = d_req_q;
  assign d_data_o = data_q;

  // R6
  mem_fires_on_token_chk: assert property (@(posedge clk) disable iff (!lrst_n)
    (d_req_q != $past(d_req_q)) |-> $past(a_req != a_ack_q));
endmodule

// File: rtl/dp_mac.sv
module dp_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          urst_n,
  input  logic          lrst_n,
  input  logic          start,
  input  logic [AW-1:0] len,
  input  logic          pend_a,
  input  logic          pend_b,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          res_ack_i,
  output logic          take_o,
  output logic          res_req_o,
  output logic [DW-1:0] res_data_o
);
  localparam int PW = 2 * DW;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic                    busy_q, busy_d;
  logic [AW-1:0]           cnt_q, cnt_d, len_q, len_d;
  logic signed [ACC_W-1:0] acc_q, acc_d, prod_x, acc_sum;
  logic [DW-1:0]           res_q, res_d, sat_v;
  logic                    res_req_q;
  logic signed [PW-1:0]    prod;
  logic                    fire, last;

  assign prod    = $signed(op_a) * $signed(op_b);
  assign prod_x  = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign acc_sum = ((cnt_q == '0) ? '0 : acc_q) + prod_x;
  assign fire    = busy_q && pend_a && pend_b && (res_req_q == res_ack_i);
  assign last    = (cnt_q == len_q - 1'b1);

  always_comb begin
    if (acc_sum > SAT_HI)      sat_v = SAT_HI[DW-1:0];
    else if (acc_sum < SAT_LO) sat_v = SAT_LO[DW-1:0];
    else                       sat_v = acc_sum[DW-1:0];
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    acc_d  = acc_q;
    res_d  = res_q;
    if (start) begin
      busy_d = (len != '0);
      cnt_d  = '0;
      len_d  = len;
    end else if (fire) begin
      acc_d = acc_sum;
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        res_d  = sat_v;
      end
    end
  end

  always_ff @(posedge clk or negedge urst_n) begin
    if (!urst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      acc_q  <= acc_d;
      res_q  <= res_d;
    end
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n)           res_req_q <= 1'b0;
    else if (fire && last) res_req_q <= ~res_req_q;
  end

  assign take_o     = fire;
  assign res_req_o  = res_req_q;
  assign res_data_o = res_q;

  // R6
  mac_idle_hold_chk: assert property (@(posedge clk) disable iff (!urst_n || !lrst_n)
    !(busy_q && pend_a && pend_b) |=> $stable(acc_q));
endmodule

// File: rtl/dp_oport.sv
module dp_oport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          lrst_n,
  input  logic          auto_ack,
  input  logic          res_req,
  input  logic [DW-1:0] res_data,
  input  logic          out_ack,
  output logic          res_ack_o,
  output logic          out_req,
  output logic [DW-1:0] out_data,
  output logic          acked_o
);
  logic ack_q, seen_q;
  logic pend, ext_edge, acked;

  assign pend     = res_req ^ ack_q;
  assign ext_edge = out_ack ^ seen_q;
  assign acked    = pend && (auto_ack || ext_edge);

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) begin
      ack_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= out_ack;
      if (acked) ack_q <= ~ack_q;
    end
  end

  assign res_ack_o = ack_q;
  assign out_req   = res_req;
  assign out_data  = res_data;
  assign acked_o   = acked;

  // R5
  oport_one_token_chk: assert property (@(posedge clk) disable iff (!lrst_n)
    (res_req != $past(res_req)) |-> ($past(res_req) == $past(ack_q)));
  // R8
  oport_ack_source_chk: assert property (@(posedge clk) disable iff (!lrst_n)
    (ack_q != $past(ack_q)) |-> $past(auto_ack || (out_ack != seen_q)));
endmodule

// File: rtl/dotp_cluster.sv
module dotp_cluster import dp_pkg::*; #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int ACC_W = 40,
  parameter int DEPTH = 16,
  parameter int CA_W  = 8
) (
  input  logic            clk,
  input  logic            rst_net_n,
  input  logic            rst_unit_n,
  input  logic            cfg_stb,
  input  logic [CA_W-1:0] cfg_addr,
  input  logic [DW-1:0]   cfg_data,
  input  logic            in_a_req,
  input  logic [DW-1:0]   in_a_data,
  output logic            in_a_ack,
  input  logic            in_b_req,
  input  logic [DW-1:0]   in_b_data,
  output logic            in_b_ack,
  output logic            out_req,
  output logic [DW-1:0]   out_data,
  input  logic            out_ack,
  output logic            done
);
  localparam int IW = $clog2(DEPTH);

  logic net_rst_n, unit_rst_n;
  dp_rst_sync i_net_sync  (.clk(clk), .arst_n(rst_net_n),  .rst_n(net_rst_n));
  dp_rst_sync i_unit_sync (.clk(clk), .arst_n(rst_unit_n), .rst_n(unit_rst_n));

  logic [AW-1:0]      base_q [NSTREAM], base_d [NSTREAM];
  logic [AW-1:0]      step_q [NSTREAM], step_d [NSTREAM];
  logic [AW-1:0]      len_q, len_d;
  logic [NSTREAM-1:0] ext_q, ext_d;
  logic               auto_q, auto_d, run_q, run_d, done_q, done_d;
  logic               start, take, acked, res_req, res_ack;
  logic [DW-1:0]      res_data;

  logic [NSTREAM-1:0] in_req, pend, x_ack;
  logic [DW-1:0]      in_data [NSTREAM], op [NSTREAM];

  assign start = cfg_stb && (cfg_addr == REG_CTRL) && cfg_data[CTRL_GO] && !run_q;

  assign in_req     = {in_b_req, in_a_req};
  assign in_data[0] = in_a_data;
  assign in_data[1] = in_b_data;
  assign in_a_ack   = x_ack[0];
  assign in_b_ack   = x_ack[1];

  always_comb begin
    len_d  = len_q;
    ext_d  = ext_q;
    auto_d = auto_q;
    run_d  = run_q;
    done_d = done_q;
    for (int s = 0; s < NSTREAM; s++) begin
      base_d[s] = base_q[s];
      step_d[s] = step_q[s];
      if (cfg_stb && (cfg_addr == REG_BASE0 + CA_W'(2*s))) base_d[s] = AW'(cfg_data);
      if (cfg_stb && (cfg_addr == REG_STEP0 + CA_W'(2*s))) step_d[s] = AW'(cfg_data);
    end
    if (cfg_stb && (cfg_addr == REG_LEN)) len_d = AW'(cfg_data);
    if (start) begin
      ext_d  = cfg_data[CTRL_EXT0 +: NSTREAM];
      auto_d = cfg_data[CTRL_AUTO];
      run_d  = (len_q != '0);
      done_d = (len_q == '0);
    end else if (acked) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge unit_rst_n) begin
    if (!unit_rst_n) begin
      for (int s = 0; s < NSTREAM; s++) begin
        base_q[s] <= '0;
        step_q[s] <= '0;
      end
      len_q  <= '0;
      ext_q  <= '0;
      auto_q <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      for (int s = 0; s < NSTREAM; s++) begin
        base_q[s] <= base_d[s];
        step_q[s] <= step_d[s];
      end
      len_q  <= len_d;
      ext_q  <= ext_d;
      auto_q <= auto_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
    logic          wr_en, ag_req, ag_ack, md_req, m_ack_q, x_ack_q;
    logic [AW-1:0] ag_addr;
    logic [DW-1:0] md_data;

    assign wr_en = cfg_stb && (cfg_addr[CA_W-1 -: 2] == 2'(s + 1))
                   && (int'(cfg_addr[CA_W-3:0]) < DEPTH);

    dp_agen #(.AW(AW)) i_agen (
      .clk(clk), .urst_n(unit_rst_n), .lrst_n(net_rst_n), .start(start),
      .enable(!cfg_data[CTRL_EXT0 + s]), .base(base_q[s]), .stride(step_q[s]),
      .len(len_q), .ack_i(ag_ack), .req_o(ag_req), .addr_o(ag_addr)
    );

    dp_mem #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_mem (
      .clk(clk), .lrst_n(net_rst_n), .wr_en(wr_en), .wr_idx(cfg_addr[IW-1:0]),
      .wr_data(cfg_data), .a_req(ag_req), .a_addr(ag_addr), .a_ack_o(ag_ack),
      .d_ack_i(m_ack_q), .d_req_o(md_req), .d_data_o(md_data)
    );

    always_ff @(posedge clk or negedge net_rst_n) begin
      if (!net_rst_n) begin
        m_ack_q <= 1'b0;
        x_ack_q <= 1'b0;
      end else if (take) begin
        if (ext_q[s]) x_ack_q <= ~x_ack_q;
        else          m_ack_q <= ~m_ack_q;
      end
    end

    assign pend[s]  = ext_q[s] ? (in_req[s] ^ x_ack_q) : (md_req ^ m_ack_q);
    assign op[s]    = ext_q[s] ? in_data[s] : md_data;
    assign x_ack[s] = x_ack_q;
  end

  dp_mac #(.DW(DW), .ACC_W(ACC_W), .AW(AW)) i_mac (
    .clk(clk), .urst_n(unit_rst_n), .lrst_n(net_rst_n), .start(start), .len(len_q),
    .pend_a(pend[0]), .pend_b(pend[1]), .op_a(op[0]), .op_b(op[1]),
    .res_ack_i(res_ack), .take_o(take), .res_req_o(res_req), .res_data_o(res_data)
  );

  dp_oport #(.DW(DW)) i_oport (
    .clk(clk), .lrst_n(net_rst_n), .auto_ack(auto_q), .res_req(res_req),
    .res_data(res_data), .out_ack(out_ack), .res_ack_o(res_ack), .out_req(out_req),
    .out_data(out_data), .acked_o(acked)
  );

  assign done = done_q;
endmodule

// File: tb/test_dotp_cluster.sv
`timescale 1ns/1ps
module test_dotp_cluster;
  logic        clk = 1'b0;
  logic        rst_net_n, rst_unit_n, cfg_stb;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_data, in_a_data, in_b_data, out_data;
  logic        in_a_req, in_a_ack, in_b_req, in_b_ack, out_req, out_ack, done;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int ma [16];
  int mb [16];

  dotp_cluster i_dotp_cluster (
    .clk(clk), .rst_net_n(rst_net_n), .rst_unit_n(rst_unit_n), .cfg_stb(cfg_stb),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_a_req(in_a_req), .in_a_data(in_a_data),
    .in_a_ack(in_a_ack), .in_b_req(in_b_req), .in_b_data(in_b_data), .in_b_ack(in_b_ack),
    .out_req(out_req), .out_data(out_data), .out_ack(out_ack), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nfail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_stb = 1'b0;
  endtask

  task automatic load_mem();
    for (int k = 0; k < 16; k++) begin
      cfg_wr(8'(8'h40 + k), 16'(ma[k]));
      cfg_wr(8'(8'h80 + k), 16'(mb[k]));
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint exp_dot(input int n, input int ba, input int sa, input int bb, input int sb);
    longint acc = 0;
    for (int i = 0; i < n; i++)
      acc += longint'(ma[(ba + i * sa) & 15]) * longint'(mb[(bb + i * sb) & 15]);
    return sat16(acc);
  endfunction

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim && !done; i++) @(negedge clk);
  endtask

  task automatic setup(input int n, input int ba, input int sa, input int bb, input int sb);
    cfg_wr(8'h01, 16'(ba)); cfg_wr(8'h02, 16'(sa));
    cfg_wr(8'h03, 16'(bb)); cfg_wr(8'h04, 16'(sb));
    cfg_wr(8'h05, 16'(n));
  endtask

  // memory-sourced run in auto-acknowledge mode
  task automatic run_dot(input int n, input int ba, input int sa, input int bb, input int sb, input string req);
    logic prev;
    longint e;
    setup(n, ba, sa, bb, sb);
    prev = out_req;
    e = exp_dot(n, ba, sa, bb, sb);
    cfg_wr(8'h00, 16'h0003);
    wait_done(200);
    check(done === 1'b1, req, longint'(done), 1);
    check($signed(out_data) == e, req, longint'($signed(out_data)), e);
    repeat (3) @(negedge clk);
    check(out_req === ~prev && done === 1'b1, "R9", longint'(out_req), longint'(~prev));
  endtask

  initial begin
    logic prev;
    longint e, acc;
    int steps [4];
    int xa [5];
    int nb_start;
    steps[0] = 0; steps[1] = 1; steps[2] = 5; steps[3] = 16'hFFFF;
    rst_net_n = 1'b0; rst_unit_n = 1'b0; cfg_stb = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_a_req = 1'b0; in_b_req = 1'b0; in_a_data = '0; in_b_data = '0; out_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_net_n = 1'b1; rst_unit_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(done === 1'b0 && out_req === 1'b0, "R12", longint'({done, out_req}), 0);
    check(in_a_ack === 1'b0 && in_b_ack === 1'b0, "R12", longint'({in_a_ack, in_b_ack}), 0);

    for (int k = 0; k < 16; k++) begin
      ma[k] = k * 7 - 50;
      mb[k] = 60 - k * 9;
    end
    load_mem();

    // R1 R2 R3 sweep over lengths and strides
    for (int n = 1; n <= 16; n++)
      for (int s = 0; s < 4; s++)
        run_dot(n, n & 15, steps[s], 3, steps[(s + 1) & 3], "R2");

    // R10 zero length
    setup(0, 0, 1, 0, 1);
    prev = out_req;
    cfg_wr(8'h00, 16'h0003);
    repeat (2) @(negedge clk);
    check(done === 1'b1, "R10", longint'(done), 1);
    repeat (20) @(negedge clk);
    check(out_req === prev, "R10", longint'(out_req), longint'(prev));

    // R11 start during a run is ignored
    setup(16, 0, 1, 0, 1);
    e = exp_dot(16, 0, 1, 0, 1);
    cfg_wr(8'h00, 16'h0003);
    check(done === 1'b0, "R9", longint'(done), 0);
    cfg_wr(8'h05, 16'd2);
    cfg_wr(8'h00, 16'h0003);
    wait_done(200);
    check($signed(out_data) == e, "R11", longint'($signed(out_data)), e);

    // R6 R7 operand A from input port with long gaps
    for (int i = 0; i < 5; i++) xa[i] = 1000 * i - 1700;
    setup(5, 0, 1, 4, 3);
    prev = out_req;
    nb_start = 4;
    acc = 0;
    for (int i = 0; i < 5; i++) acc += longint'(xa[i]) * longint'(mb[(nb_start + 3 * i) & 15]);
    cfg_wr(8'h00, 16'h0007);
    for (int i = 0; i < 5; i++) begin
      repeat (12) @(negedge clk);
      check(out_req === prev && done === 1'b0, "R6", longint'({out_req, done}), longint'({prev, 1'b0}));
      in_a_data = 16'(xa[i]);
      in_a_req = ~in_a_req;
      for (int w = 0; w < 20 && in_a_ack !== in_a_req; w++) @(negedge clk);
      check(in_a_ack === in_a_req, "R7", longint'(in_a_ack), longint'(in_a_req));
    end
    wait_done(50);
    check(done === 1'b1 && out_req === ~prev, "R7", longint'({done, out_req}), longint'({1'b1, ~prev}));
    check($signed(out_data) == sat16(acc), "R7", longint'($signed(out_data)), sat16(acc));

    // R8 receiver-driven acknowledge
    setup(3, 2, 1, 5, 2);
    e = exp_dot(3, 2, 1, 5, 2);
    prev = out_req;
    cfg_wr(8'h00, 16'h0001);
    for (int w = 0; w < 100 && out_req === prev; w++) @(negedge clk);
    check(out_req === ~prev, "R8", longint'(out_req), longint'(~prev));
    repeat (6) @(negedge clk);
    check(done === 1'b0, "R8", longint'(done), 0);
    check($signed(out_data) == e, "R8", longint'($signed(out_data)), e);
    out_ack = ~out_ack;
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R8", longint'(done), 1);

    // R3 R4 wide intermediate sum, final value in range
    for (int k = 0; k < 16; k++) begin ma[k] = 0; mb[k] = 0; end
    ma[0] = 30000; mb[0] = 30000; ma[1] = 30000; mb[1] = -30000; ma[2] = 5; mb[2] = 7;
    load_mem();
    run_dot(3, 0, 1, 0, 1, "R3");
    check($signed(out_data) == 35, "R4", longint'($signed(out_data)), 35);

    // R4 saturation high and low
    for (int k = 0; k < 16; k++) begin ma[k] = 32767; mb[k] = 32767; end
    load_mem();
    run_dot(16, 0, 1, 0, 1, "R4");
    for (int k = 0; k < 16; k++) mb[k] = -32768;
    load_mem();
    run_dot(16, 0, 1, 0, 1, "R4");

    // R12 independent resets
    if (out_req === 1'b0) run_dot(1, 0, 1, 0, 1, "R12");
    @(negedge clk);
    rst_net_n = 1'b0; in_a_req = 1'b0; in_b_req = 1'b0; out_ack = 1'b0;
    @(negedge clk);
    check(out_req === 1'b0 && done === 1'b1, "R12", longint'({out_req, done}), 1);
    rst_net_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_unit_n = 1'b0;
    @(negedge clk);
    check(done === 1'b0, "R12", longint'(done), 0);
    rst_unit_n = 1'b1;
    repeat (3) @(negedge clk);
    run_dot(4, 1, 2, 3, 1, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule